// File: doc/BRIEF.md
# Sequential Line Prefetch Buffer

This block sits beside a first-level cache on its refill side and holds lines fetched ahead of demand. When the cache looks up a missing line, the block compares the line address with the oldest entry only. A match whose data has arrived is handed to the cache one cycle later and leaves the buffer. Any other lookup empties the buffer and restarts fetching at the line after the missed one. The cache then fetches the missed line itself.

While it has free slots, the block keeps sending requests for successive lines to a pipelined next-level memory. Several requests can be in flight at once, and the memory answers them in the order they were sent. Prefetched lines stay in the buffer and reach the cache only when a lookup asks for them. A restart throws away any answers still owed for the discarded entries. Line addresses run modulo the address width.

Top module: `seqpf_top`

## Requirements
- R1: After reset the buffer is empty and no stream is active: `memReqValid` is 0, `missReady` is 1, and `fillValid` and `missNoHit` are 0. No request is made before the first lookup that misses.
- R2: A lookup that does not match the oldest entry raises `missNoHit` for one cycle, in the cycle after acceptance. Requests then go out for the following line addresses in ascending order, starting at the line after the miss and stepping by `LINE_BYTES`. They wrap modulo 2^`ADDR_W`.
- R3: At most `DEPTH` lines are held or requested at once. With no lookups, exactly `DEPTH` requests follow a restart and then `memReqValid` stays 0.
- R4: A lookup whose line address equals the oldest entry's, with that entry's data present, raises `fillValid` for one cycle in the cycle after acceptance. `fillAddr` then carries the line address with the offset bits cleared, and `fillData` carries the returned line. The entry is removed, which permits exactly one further request.
- R5: If the oldest entry matches but its data has not returned, `missReady` is held at 0 until the data arrives, and the lookup then completes as a hit.
- R6: Only the oldest entry is compared: a lookup matching a younger entry is treated as a miss and restarts the stream.
- R7: Answers still owed for entries discarded by a restart are dropped, and later entries receive only their own data.
- R8: While `memReqReady` is 0, a pending request keeps `memReqValid` at 1 and `memReqAddr` unchanged.
- R9: `fillValid` is raised only in the cycle after an accepted lookup. Prefetched lines are never delivered unasked.
- R10: The low log2(`LINE_BYTES`) offset bits of `missAddr` take no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Cache lookup request |
| missAddr | input | ADDR_W | Byte address of the missing line |
| missReady | output | 1 | Lookup accepted this cycle when high |
| fillValid | output | 1 | Line delivered to the cache (one cycle) |
| fillAddr | output | ADDR_W | Line-aligned address of the delivered line |
| fillData | output | LINE_W | Delivered line data |
| missNoHit | output | 1 | Lookup missed the buffer (one cycle) |
| memReqValid | output | 1 | Prefetch request to next-level memory |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqAddr | output | ADDR_W | Line-aligned prefetch address |
| memRspValid | input | 1 | Response beat, in request order |
| memRspData | input | LINE_W | Response line data |

## Verification
The bench builds the block with `DEPTH`=4, `LINE_BYTES`=16, `ADDR_W`=16 and `LINE_W`=32. With these values a full buffer, a pop and its refill, and a restart all fit in a few cycles. The 16-bit address lets the bench reach the wrap from the top line to line zero. The bench's memory model has a latency that can be changed during the run. The bench sweeps sequential streams across latencies 1 to 6, which covers lookups that find data already present and lookups that must stall. A latency of 8 keeps answers in flight across a restart, so discarded responses are present when it happens.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic pop;    // head entry leaves, its line goes to the cache
    logic flush;  // empty all entries and restart the stream
    logic issue;  // prefetch request accepted by memory
    logic fill;   // response written into the oldest waiting entry
    logic drop;   // response belongs to a discarded entry
  } seqpf_strobe_t;

endpackage

// File: rtl/seqpf_ctrl.sv
module seqpf_ctrl
  import seqpf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          missValid,
  input  logic          headMatch,
  input  logic          headAvail,
  input  logic          slotFree,
  input  logic          outFree,
  input  logic          dropPend,
  input  logic          memReqReady,
  input  logic          memRspValid,
  output logic          missReady,
  output logic          memReqValid,
  output logic          fillValid,
  output logic          missNoHit,
  output seqpf_strobe_t stb
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  ctrlState_e stateQ;
  logic       accept;

  // A matching head without data holds the lookup off.
  assign missReady   = !(headMatch && !headAvail);
  assign accept      = missValid && missReady;

  assign stb.pop     = accept && headMatch;
  assign stb.flush   = accept && !headMatch;

  // No request in a restart cycle: the next address is being reloaded.
  assign memReqValid = (stateQ == ST_RUN) && slotFree && outFree && !stb.flush;
  assign stb.issue   = memReqValid && memReqReady;

  // A response arriving while entries are cleared is stale as well.
  assign stb.drop    = memRspValid && (dropPend || stb.flush);
  assign stb.fill    = memRspValid && !dropPend && !stb.flush;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      fillValid <= 1'b0;
      missNoHit <= 1'b0;
    end else begin
      if (stb.flush) stateQ <= ST_RUN;
      fillValid <= stb.pop;
      missNoHit <= stb.flush;
    end
  end

endmodule

// File: rtl/seqpf_data.sv
module seqpf_data
  import seqpf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINE_W     = 64,
  parameter int DEPTH      = 4,
  parameter int MAX_OUT    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqpf_strobe_t                 stb,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] missTag,
  input  logic [LINE_W-1:0]             memRspData,
  output logic                          headMatch,
  output logic                          headAvail,
  output logic                          slotFree,
  output logic                          outFree,
  output logic                          dropPend,
  output logic [ADDR_W-1:0]             memReqAddr,
  output logic [ADDR_W-1:0]             fillAddr,
  output logic [LINE_W-1:0]             fillData,
  output logic [$clog2(DEPTH+1)-1:0]    occCnt
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t nextPtr(input ptr_t p);
    return (p == ptr_t'(DEPTH - 1)) ? ptr_t'(0) : ptr_t'(p + ptr_t'(1));
  endfunction

  // Entry storage
  logic [TAG_W-1:0]  tagQ   [DEPTH];
  logic [LINE_W-1:0] dataQ  [DEPTH];
  logic              validQ [DEPTH];
  logic              availQ [DEPTH];

  // Pointers and counters
  ptr_t              headQ, tailQ, fillPtrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [OUT_W-1:0]  outCntQ, dropCntQ;
  logic [TAG_W-1:0]  nextTagQ;
  logic              rspTaken;

  assign rspTaken   = stb.fill || stb.drop;

  assign headMatch  = validQ[headQ] && (tagQ[headQ] == missTag);
  assign headAvail  = availQ[headQ];
  assign slotFree   = cntQ < CNT_W'(DEPTH);
  assign outFree    = outCntQ < OUT_W'(MAX_OUT);
  assign dropPend   = dropCntQ != '0;
  assign memReqAddr = {nextTagQ, {OFF_W{1'b0}}};
  assign occCnt     = cntQ;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        availQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        dataQ[g]  <= '0;
      end else if (stb.flush) begin
        validQ[g] <= 1'b0;
        availQ[g] <= 1'b0;
      end else begin
        if (stb.pop && headQ == ptr_t'(g)) begin
          validQ[g] <= 1'b0;
          availQ[g] <= 1'b0;
        end
        if (stb.issue && tailQ == ptr_t'(g)) begin
          validQ[g] <= 1'b1;
          availQ[g] <= 1'b0;
          tagQ[g]   <= nextTagQ;
        end
        if (stb.fill && fillPtrQ == ptr_t'(g)) begin
          availQ[g] <= 1'b1;
          dataQ[g]  <= memRspData;
        end
      end
    end
  end

  // Ring pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ    <= '0;
      tailQ    <= '0;
      fillPtrQ <= '0;
      cntQ     <= '0;
    end else if (stb.flush) begin
      headQ    <= '0;
      tailQ    <= '0;
      fillPtrQ <= '0;
      cntQ     <= '0;
    end else begin
      if (stb.pop)   headQ    <= nextPtr(headQ);
      if (stb.issue) tailQ    <= nextPtr(tailQ);
      if (stb.fill)  fillPtrQ <= nextPtr(fillPtrQ);
      cntQ <= cntQ + CNT_W'(stb.issue) - CNT_W'(stb.pop);
    end
  end

  // Outstanding requests and how many of them are stale
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCntQ  <= '0;
      dropCntQ <= '0;
    end else begin
      outCntQ <= outCntQ + OUT_W'(stb.issue) - OUT_W'(rspTaken);
      if (stb.flush)     dropCntQ <= outCntQ - OUT_W'(rspTaken);
      else if (stb.drop) dropCntQ <= dropCntQ - OUT_W'(1);
    end
  end

  // Next prefetch line address
  always_ff @(posedge clk) begin
    if (!rstN)          nextTagQ <= '0;
    else if (stb.flush) nextTagQ <= missTag + TAG_W'(1);
    else if (stb.issue) nextTagQ <= nextTagQ + TAG_W'(1);
  end

  // Line handed to the cache
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillAddr <= '0;
      fillData <= '0;
    end else if (stb.pop) begin
      fillAddr <= {tagQ[headQ], {OFF_W{1'b0}}};
      fillData <= dataQ[headQ];
    end
  end

endmodule

// File: rtl/seqpf_top.sv
module seqpf_top
  import seqpf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINE_W     = 64,
  parameter int DEPTH      = 4,
  parameter int MAX_OUT    = 2 * DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LINE_W-1:0] fillData,
  output logic              missNoHit,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [LINE_W-1:0] memRspData
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W = $clog2(DEPTH + 1);

  seqpf_strobe_t    stb;
  logic             headMatch, headAvail, slotFree, outFree, dropPend;
  logic             flushStb;
  logic [CNT_W-1:0] occCnt;
  logic             unusedOff;

  assign unusedOff = ^missAddr[OFF_W-1:0];
  assign flushStb  = stb.flush;

  seqpf_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .missValid  (missValid),
    .headMatch  (headMatch),
    .headAvail  (headAvail),
    .slotFree   (slotFree),
    .outFree    (outFree),
    .dropPend   (dropPend),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .missReady  (missReady),
    .memReqValid(memReqValid),
    .fillValid  (fillValid),
    .missNoHit  (missNoHit),
    .stb        (stb)
  );

  seqpf_data #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .LINE_W    (LINE_W),
    .DEPTH     (DEPTH),
    .MAX_OUT   (MAX_OUT)
  ) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .missTag    (missAddr[ADDR_W-1:OFF_W]),
    .memRspData (memRspData),
    .headMatch  (headMatch),
    .headAvail  (headAvail),
    .slotFree   (slotFree),
    .outFree    (outFree),
    .dropPend   (dropPend),
    .memReqAddr (memReqAddr),
    .fillAddr   (fillAddr),
    .fillData   (fillData),
    .occCnt     (occCnt)
  );

endmodule

// File: rtl/seqpf_chk.sv
module seqpf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int DEPTH      = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       missValid,
  input logic                       missReady,
  input logic                       missNoHit,
  input logic                       fillValid,
  input logic                       memReqValid,
  input logic                       memReqReady,
  input logic [ADDR_W-1:0]          memReqAddr,
  input logic                       flushStb,
  input logic [$clog2(DEPTH+1)-1:0] occCnt
);

  logic              seenRestart;
  logic              haveLast;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRestart <= 1'b0;
      haveLast    <= 1'b0;
      lastAddr    <= '0;
    end else begin
      if (flushStb) begin
        seenRestart <= 1'b1;
        haveLast    <= 1'b0;
      end else if (memReqValid && memReqReady) begin
        haveLast <= 1'b1;
        lastAddr <= memReqAddr;
      end
    end
  end

  p_quiet_until_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> seenRestart);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && haveLast) |->
      memReqAddr == ADDR_W'(lastAddr + ADDR_W'(LINE_BYTES)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occCnt <= ($clog2(DEPTH+1))'(DEPTH));

  p_full_no_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> occCnt < ($clog2(DEPTH+1))'(DEPTH));

  p_one_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(fillValid && missNoHit));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !(missValid && missReady)) |=>
      (memReqValid && $stable(memReqAddr)));

  p_fill_on_demand_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $past(missValid && missReady));

endmodule

bind seqpf_top seqpf_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .DEPTH     (DEPTH)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .missValid  (missValid),
  .missReady  (missReady),
  .missNoHit  (missNoHit),
  .fillValid  (fillValid),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .flushStb   (flushStb),
  .occCnt     (occCnt)
);

// File: tb/test_seqpf_top.sv
module test_seqpf_top;

  localparam int AW = 16;
  localparam int LW = 32;
  localparam int LB = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          missValid = 1'b0;
  logic [AW-1:0] missAddr = '0;
  logic          missReady, fillValid, missNoHit, memReqValid;
  logic [AW-1:0] fillAddr, memReqAddr;
  logic [LW-1:0] fillData;
  logic          memReqReady = 1'b1;
  logic          memRspValid = 1'b0;
  logic [LW-1:0] memRspData = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int memLat = 3;
  int fillCount = 0;

  logic [AW-1:0] qAddr [0:4095];
  int            qDue  [0:4095];
  int            qWr = 0, qRd = 0;
  logic [AW-1:0] issueLog [0:4095];
  int            issueN = 0;

  seqpf_top #(.ADDR_W(AW), .LINE_BYTES(LB), .LINE_W(LW), .DEPTH(DP)) i_seqpf_top (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missReady(missReady), .fillValid(fillValid), .fillAddr(fillAddr),
    .fillData(fillData), .missNoHit(missNoHit), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  always #2.5 clk = ~clk;

  function automatic logic [LW-1:0] lineOf(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // Pipelined in-order memory: responses driven at the falling edge,
  // requests captured just before the rising edge that accepts them.
  always begin
    @(negedge clk);
    cyc++;
    if (qRd < qWr && qDue[qRd] <= cyc) begin
      memRspValid = 1'b1;
      memRspData  = lineOf(qAddr[qRd]);
      qRd++;
    end else begin
      memRspValid = 1'b0;
    end
    #2;
    if (rstN && memReqValid && memReqReady) begin
      qAddr[qWr] = memReqAddr;
      qDue[qWr]  = cyc + memLat;
      qWr++;
      issueLog[issueN] = memReqAddr;
      issueN++;
    end
  end

  always @(negedge clk) if (fillValid) fillCount++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic lookup(input logic [AW-1:0] a, output bit hit, output bit nohit,
                        output logic [LW-1:0] d, output logic [AW-1:0] la,
                        output int stall);
    stall = 0;
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = a;
    #1;
    while (!missReady) begin
      stall++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    missValid = 1'b0;
    #1;
    hit = fillValid; nohit = missNoHit; d = fillData; la = fillAddr;
  endtask

  task automatic expectHit(input logic [AW-1:0] a, input string req);
    bit h, n; logic [LW-1:0] d; logic [AW-1:0] la; int s;
    logic [AW-1:0] line;
    line = {a[AW-1:4], 4'h0};
    lookup(a, h, n, d, la, s);
    chk(h && !n, req, "hit flag", {h, n}, 2'b10);
    chk(d == lineOf(line), req, "hit data", d, lineOf(line));
    chk(la == line, req, "hit line address", la, line);
  endtask

  task automatic expectMiss(input logic [AW-1:0] a, input string req);
    bit h, n; logic [LW-1:0] d; logic [AW-1:0] la; int s;
    lookup(a, h, n, d, la, s);
    chk(n && !h, req, "miss flag", {h, n}, 2'b01);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int fc;
    bit h, n; logic [LW-1:0] d; logic [AW-1:0] la; int s;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    // R1: reset state
    chk(!memReqValid, "R1", "memReqValid", memReqValid, 0);
    chk(missReady, "R1", "missReady", missReady, 1);
    chk(!fillValid && !missNoHit, "R1", "results", {fillValid, missNoHit}, 0);
    idle(5);
    chk(issueN == 0, "R1", "requests before first miss", issueN, 0);

    // R2/R3/R10: restart from a miss with nonzero offset, fill to depth
    base = issueN;
    expectMiss(16'h0104, "R2");
    idle(20);
    chk(issueN - base == DP, "R3", "requests after restart", issueN - base, DP);
    for (int k = 0; k < DP; k++)
      chk(issueLog[base + k] == 16'h0110 + 16'(k * LB), "R2", "sequential address",
          issueLog[base + k], 16'h0110 + 16'(k * LB));
    chk(!memReqValid, "R3", "idle when full", memReqValid, 0);

    // R4/R10: head hit with offset bits set, one refill request
    base = issueN;
    expectHit(16'h011C, "R10");
    idle(10);
    chk(issueN - base == 1, "R4", "one refill request", issueN - base, 1);
    chk(issueLog[base] == 16'h0150, "R4", "refill address", issueLog[base], 16'h0150);
    for (int k = 0; k < 4; k++) expectHit(16'h0120 + 16'(k * LB), "R4");

    // R9: resident lines never delivered unasked
    idle(12);
    fc = fillCount;
    idle(12);
    chk(fillCount == fc, "R9", "spontaneous deliveries", fillCount - fc, 0);

    // R5: head matches before data returns
    memLat = 6;
    expectMiss(16'h0800, "R2");
    lookup(16'h0810, h, n, d, la, s);
    chk(s > 0, "R5", "stall cycles", s, 1);
    chk(h && d == lineOf(16'h0810), "R5", "data after stall", d, lineOf(16'h0810));
    memLat = 3;

    // R6: younger entry match still restarts
    idle(20);
    base = issueN;
    expectMiss(16'h0830, "R6");
    idle(20);
    for (int k = 0; k < DP; k++)
      chk(issueLog[base + k] == 16'h0840 + 16'(k * LB), "R6", "restart address",
          issueLog[base + k], 16'h0840 + 16'(k * LB));

    // R7: restart with responses in flight
    memLat = 8;
    expectMiss(16'h2000, "R7");
    idle(2);
    expectMiss(16'h5000, "R7");
    expectHit(16'h5010, "R7");
    expectHit(16'h5020, "R7");
    memLat = 3;
    idle(20);

    // R8: request held while memory not ready
    memReqReady = 1'b0;
    base = issueN;
    expectMiss(16'h3000, "R8");
    idle(1);
    chk(memReqValid && memReqAddr == 16'h3010, "R8", "pending request", memReqAddr, 16'h3010);
    idle(3);
    chk(memReqValid && memReqAddr == 16'h3010, "R8", "held request", memReqAddr, 16'h3010);
    chk(issueN == base, "R8", "no acceptance", issueN - base, 0);
    memReqReady = 1'b1;
    idle(10);
    chk(issueLog[base] == 16'h3010, "R8", "released address", issueLog[base], 16'h3010);

    // R2: address wrap at top of space
    expectMiss(16'hFFF8, "R2");
    expectHit(16'h0004, "R2");

    // R4: stream sweep across memory latencies
    for (int lat = 1; lat <= 6; lat++) begin
      memLat = lat;
      expectMiss(16'h4000 + 16'(lat * 256), "R2");
      for (int k = 1; k <= 8; k++)
        expectHit(16'h4000 + 16'(lat * 256) + 16'(k * LB), "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule